// File: doc/BRIEF.md
# Interrupt Priority Selection and Signalling

This block models the part of a processor's interrupt interface that decides which waiting interrupt should reach the core. It holds five things for each interrupt: a pending flag, an active flag, an enable, a group code and an 8-bit priority. Each cycle it picks the best candidate. It reports that candidate on a highest-pending output, and it raises IRQ or FIQ only when the candidate also clears the priority mask, the running-priority preemption test and its group's enable.

Software-side activity arrives as single-cycle pulses. A configuration write sets the enable, group and priority of one interrupt. A pend pulse marks one interrupt as pending. An acknowledge takes the signalled interrupt into service. An end-of-interrupt retires one active interrupt. Running priorities of preempted handlers are kept on a small stack, so nested handlers unwind in order.

Top module: `intr_signal_sel`

## Requirements
- R1: After reset, hp_id reads 1023, hp_prio reads 0xFF, irq and fiq are low and run_prio reads 0xFF (idle).
- R2: A candidate is an interrupt that is pending, enabled and not active. hp_id shows the candidate with the numerically lowest priority value, and a tie goes to the lower ID. With no candidate, hp_id reads 1023. Outputs follow a state change two clock edges later: one edge updates the state and the next registers the outputs.
- R3: hp_id and hp_prio are reported whatever the values of pmr, run_prio and grp_en.
- R4: The selected candidate is signalled only when its priority value is strictly below pmr.
- R5: The selected candidate is signalled only when its priority value is strictly below run_prio, which is the preemption rule.
- R6: The selected candidate is signalled only when the grp_en bit of its group is set. grp_en bit 0 enables group code 0, bit 1 enables code 1 and bit 2 enables code 2. Group code 3 is never signalled.
- R7: Group code 0 (group 0) and group code 2 (group 1 of the other security state) are signalled on fiq. Group code 1 (group 1 of the current state) is signalled on irq. irq and fiq are never high together.
- R8: An ack pulse while irq or fiq is high moves the interrupt shown on hp_id from pending to active and sets run_prio to its priority. An ack pulse while neither line is high has no effect.
- R9: An eoi pulse for an active ID clears that ID's active flag and restores run_prio to the value it had before the matching acknowledge. An eoi pulse for an ID that is not active has no effect.
- R10: An interrupt that is made pending while it is active is not a candidate until its end-of-interrupt.
- R11: At most STACK_DEPTH interrupts can be in service at once. An ack pulse while STACK_DEPTH are in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | 4 | ID being configured |
| cfg_en | input | 1 | Enable value to write |
| cfg_grp | input | 2 | Group code to write (0, 1, 2, 3) |
| cfg_prio | input | 8 | Priority value to write, lower is more urgent |
| pend_set | input | 1 | Mark pend_id pending |
| pend_id | input | 4 | ID to make pending |
| pmr | input | 8 | Priority mask |
| grp_en | input | 3 | Per-group signalling enables |
| ack | input | 1 | Acknowledge the signalled interrupt |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 4 | ID being retired |
| hp_id | output | 10 | Highest-pending ID, 1023 when none |
| hp_prio | output | 8 | Priority of hp_id, 0xFF when none |
| irq | output | 1 | Interrupt request line |
| fiq | output | 1 | Fast interrupt request line |
| run_prio | output | 8 | Current running priority |

## Verification
A corrupted pending or active flag shows on hp_id two edges after the corruption. The damaged interrupt either appears among the candidates or drops out of them. A wrong entry on the preemption stack stays hidden until the end-of-interrupt that pops it. At that point run_prio shows the wrong value, and a candidate that should be signalled stays silent on irq and fiq, or one that should be held back is signalled. The bench therefore retires nested handlers one at a time and checks run_prio and both request lines after each step.

// File: rtl/isel_pkg.sv
package isel_pkg;
  typedef enum logic [1:0] {
    GRP_SEC0   = 2'd0,
    GRP_G1_CUR = 2'd1,
    GRP_G1_OTH = 2'd2,
    GRP_NONE   = 2'd3
  } grp_e;
endpackage

// File: rtl/isel_state_bank.sv
module isel_state_bank
  import isel_pkg::*;
#(
  parameter int NUM_INT = 16,
  parameter int PRIO_W  = 8,
  parameter int INT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [INT_W-1:0]  cfg_id,
  input  logic              cfg_en,
  input  grp_e              cfg_grp,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              pend_set,
  input  logic [INT_W-1:0]  pend_id,
  input  logic              ack_do,
  input  logic [INT_W-1:0]  ack_id,
  input  logic              eoi_do,
  input  logic [INT_W-1:0]  eoi_id,
  output logic              pend_o [NUM_INT],
  output logic              act_o  [NUM_INT],
  output logic              en_o   [NUM_INT],
  output grp_e              grp_o  [NUM_INT],
  output logic [PRIO_W-1:0] prio_o [NUM_INT]
);
  for (genvar i = 0; i < NUM_INT; i++) begin : g_slot
    localparam logic [INT_W-1:0] MY_ID = INT_W'(i);

    // Flags: pend set wins over an acknowledge clear in the same cycle.
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_o[i] <= 1'b0;
        act_o[i]  <= 1'b0;
      end else begin
        if (pend_set && pend_id == MY_ID)
          pend_o[i] <= 1'b1;
        else if (ack_do && ack_id == MY_ID)
          pend_o[i] <= 1'b0;
        if (ack_do && ack_id == MY_ID)
          act_o[i] <= 1'b1;
        else if (eoi_do && eoi_id == MY_ID)
          act_o[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        en_o[i]   <= 1'b0;
        grp_o[i]  <= GRP_SEC0;
        prio_o[i] <= '1;
      end else if (cfg_we && cfg_id == MY_ID) begin
        en_o[i]   <= cfg_en;
        grp_o[i]  <= cfg_grp;
        prio_o[i] <= cfg_prio;
      end
    end
  end
endmodule

// File: rtl/isel_pick.sv
module isel_pick #(
  parameter int NUM_INT = 16,
  parameter int PRIO_W  = 8,
  parameter int INT_W   = 4
) (
  input  logic              cand   [NUM_INT],
  input  logic [PRIO_W-1:0] prio   [NUM_INT],
  output logic              found,
  output logic [INT_W-1:0]  best_idx,
  output logic [PRIO_W-1:0] best_prio
);
  // Ascending scan with strict compare keeps the lower ID on a tie.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_INT; i++) begin
      if (cand[i] && (!found || prio[i] < best_prio)) begin
        found     = 1'b1;
        best_idx  = INT_W'(i);
        best_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/isel_run_stack.sv
module isel_run_stack #(
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [PRIO_W-1:0] run_prio,
  output logic              full,
  output logic [CNT_W-1:0]  depth
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PRIO_W-1:0] stk [DEPTH];
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              do_push;

  assign full    = (depth == FULL);
  assign do_push = push && !pop && !full;
  assign wr_idx  = IDX_W'(depth);
  assign rd_idx  = IDX_W'(depth - ONE);

  // Storage without reset so it can map onto distributed or block RAM.
  always_ff @(posedge clk) begin
    if (do_push) stk[wr_idx] <= run_prio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_prio <= '1;
      depth    <= '0;
    end else if (pop) begin
      if (depth != '0) begin
        run_prio <= stk[rd_idx];
        depth    <= depth - ONE;
      end else begin
        run_prio <= '1;
      end
    end else if (do_push) begin
      run_prio <= push_prio;
      depth    <= depth + ONE;
    end
  end
endmodule

// File: rtl/intr_signal_sel.sv
module intr_signal_sel
  import isel_pkg::*;
#(
  parameter int NUM_INT     = 16,
  parameter int PRIO_W      = 8,
  parameter int ID_W        = 10,
  parameter int STACK_DEPTH = 4,
  localparam int INT_W      = $clog2(NUM_INT),
  localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [INT_W-1:0]  cfg_id,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_grp,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              pend_set,
  input  logic [INT_W-1:0]  pend_id,
  input  logic [PRIO_W-1:0] pmr,
  input  logic [2:0]        grp_en,
  input  logic              ack,
  input  logic              eoi,
  input  logic [INT_W-1:0]  eoi_id,
  output logic [ID_W-1:0]   hp_id,
  output logic [PRIO_W-1:0] hp_prio,
  output logic              irq,
  output logic              fiq,
  output logic [PRIO_W-1:0] run_prio
);
  localparam logic [ID_W-1:0] SPURIOUS = ID_W'(1023);

  logic              pend [NUM_INT];
  logic              act  [NUM_INT];
  logic              en   [NUM_INT];
  grp_e              grp  [NUM_INT];
  logic [PRIO_W-1:0] prio [NUM_INT];
  logic              cand [NUM_INT];

  logic              found;
  logic [INT_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;
  logic              hp_valid_q;
  logic [INT_W-1:0]  hp_idx_q;
  logic              stk_full;
  logic [CNT_W-1:0]  stk_depth;
  logic              ack_do;
  logic              eoi_do;
  grp_e              sel_grp;
  logic              grp_ok;
  logic              pass;

  isel_state_bank #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W), .INT_W(INT_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_id   (cfg_id),
    .cfg_en   (cfg_en),
    .cfg_grp  (grp_e'(cfg_grp)),
    .cfg_prio (cfg_prio),
    .pend_set (pend_set),
    .pend_id  (pend_id),
    .ack_do   (ack_do),
    .ack_id   (hp_idx_q),
    .eoi_do   (eoi_do),
    .eoi_id   (eoi_id),
    .pend_o   (pend),
    .act_o    (act),
    .en_o     (en),
    .grp_o    (grp),
    .prio_o   (prio)
  );

  for (genvar i = 0; i < NUM_INT; i++) begin : g_cand
    assign cand[i] = pend[i] && en[i] && !act[i];
  end

  isel_pick #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W), .INT_W(INT_W)) u_pick (
    .cand      (cand),
    .prio      (prio),
    .found     (found),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  // An acknowledge only acts on what the core currently sees signalled.
  assign ack_do = ack && !eoi && (irq || fiq) && hp_valid_q &&
                  pend[hp_idx_q] && !act[hp_idx_q] && !stk_full;
  assign eoi_do = eoi && act[eoi_id];

  isel_run_stack #(.PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (ack_do),
    .push_prio (hp_prio),
    .pop       (eoi_do),
    .run_prio  (run_prio),
    .full      (stk_full),
    .depth     (stk_depth)
  );

  assign sel_grp = grp[best_idx];

  always_comb begin
    unique case (sel_grp)
      GRP_SEC0:   grp_ok = grp_en[0];
      GRP_G1_CUR: grp_ok = grp_en[1];
      GRP_G1_OTH: grp_ok = grp_en[2];
      default:    grp_ok = 1'b0;
    endcase
  end

  assign pass = found && grp_ok && (best_prio < pmr) && (best_prio < run_prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_valid_q <= 1'b0;
      hp_idx_q   <= '0;
      hp_id      <= SPURIOUS;
      hp_prio    <= '1;
      irq        <= 1'b0;
      fiq        <= 1'b0;
    end else begin
      hp_valid_q <= found;
      hp_idx_q   <= best_idx;
      hp_id      <= found ? ID_W'(best_idx) : SPURIOUS;
      hp_prio    <= found ? best_prio : '1;
      irq        <= pass && (sel_grp == GRP_G1_CUR);
      fiq        <= pass && (sel_grp == GRP_SEC0 || sel_grp == GRP_G1_OTH);
    end
  end
endmodule

// File: rtl/intr_signal_sel_chk.sv
module intr_signal_sel_chk #(
  parameter int PRIO_W = 8,
  parameter int ID_W   = 10,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [PRIO_W-1:0] pmr,
  input logic [PRIO_W-1:0] run_prio,
  input logic [ID_W-1:0]   hp_id,
  input logic [PRIO_W-1:0] hp_prio,
  input logic              irq,
  input logic              fiq,
  input logic              ack,
  input logic              eoi,
  input logic [CNT_W-1:0]  depth
);
  localparam logic [ID_W-1:0]  SPUR  = ID_W'(1023);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

  p_one_line_r7: assert property (@(posedge clk) disable iff (rst)
    !(irq && fiq));

  p_below_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (irq || fiq) |-> (hp_prio < $past(pmr)));

  p_preempts_r5: assert property (@(posedge clk) disable iff (rst)
    (irq || fiq) |-> (hp_prio < $past(run_prio)));

  p_spurious_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (hp_id == SPUR) |-> (!irq && !fiq));

  p_depth_bound_r11: assert property (@(posedge clk) disable iff (rst)
    depth <= LIMIT);

  p_run_moves_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(run_prio) |-> $past(ack || eoi));
endmodule

bind intr_signal_sel intr_signal_sel_chk #(
  .PRIO_W (PRIO_W),
  .ID_W   (ID_W),
  .CNT_W  (CNT_W),
  .DEPTH  (STACK_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pmr      (pmr),
  .run_prio (run_prio),
  .hp_id    (hp_id),
  .hp_prio  (hp_prio),
  .irq      (irq),
  .fiq      (fiq),
  .ack      (ack),
  .eoi      (eoi),
  .depth    (stk_depth)
);

// File: tb/intr_signal_sel_bench.sv
module intr_signal_sel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_id = '0;
  logic       cfg_en = 1'b0;
  logic [1:0] cfg_grp = '0;
  logic [7:0] cfg_prio = '0;
  logic       pend_set = 1'b0;
  logic [3:0] pend_id = '0;
  logic [7:0] pmr = 8'hF0;
  logic [2:0] grp_en = 3'b111;
  logic       ack = 1'b0;
  logic       eoi = 1'b0;
  logic [3:0] eoi_id = '0;
  logic [9:0] hp_id;
  logic [7:0] hp_prio;
  logic       irq;
  logic       fiq;
  logic [7:0] run_prio;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  intr_signal_sel #(.STACK_DEPTH(2)) u_intr_signal_sel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_en(cfg_en),
    .cfg_grp(cfg_grp), .cfg_prio(cfg_prio), .pend_set(pend_set),
    .pend_id(pend_id), .pmr(pmr), .grp_en(grp_en), .ack(ack), .eoi(eoi),
    .eoi_id(eoi_id), .hp_id(hp_id), .hp_prio(hp_prio), .irq(irq), .fiq(fiq),
    .run_prio(run_prio)
  );

  typedef struct packed {
    logic [3:0] id;
    logic       en;
    logic [1:0] grp;
    logic [7:0] prio;
    logic [9:0] exp_id;
    logic       exp_irq;
    logic       exp_fiq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd5,  1'b1, 2'd1, 8'h80, 10'd5, 1'b1, 1'b0},
    '{4'd3,  1'b1, 2'd0, 8'h80, 10'd3, 1'b0, 1'b1},
    '{4'd9,  1'b1, 2'd2, 8'h40, 10'd9, 1'b0, 1'b1},
    '{4'd12, 1'b0, 2'd1, 8'h10, 10'd9, 1'b0, 1'b1},
    '{4'd7,  1'b1, 2'd1, 8'h40, 10'd7, 1'b1, 1'b0},
    '{4'd0,  1'b1, 2'd1, 8'hF8, 10'd7, 1'b1, 1'b0}
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic configure(input logic [3:0] id, input logic e, input logic [1:0] g,
                           input logic [7:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_id = id; cfg_en = e; cfg_grp = g; cfg_prio = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic make_pending(input logic [3:0] id);
    @(negedge clk);
    pend_set = 1'b1; pend_id = id;
    @(negedge clk);
    pend_set = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic pulse_eoi(input logic [3:0] id);
    @(negedge clk);
    eoi = 1'b1; eoi_id = id;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [9:0] id, input logic i,
                            input logic f, input logic [7:0] rp);
    check({tag, " hp_id"}, 32'(hp_id), 32'(id));
    check({tag, " irq"}, 32'(irq), 32'(i));
    check({tag, " fiq"}, 32'(fiq), 32'(f));
    check({tag, " run_prio"}, 32'(run_prio), 32'(rp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    expect_out("R1 reset", 10'd1023, 1'b0, 1'b0, 8'hFF);
    check("R1 hp_prio", 32'(hp_prio), 32'hFF);
    rst = 1'b0;
    settle();
    // R2: no candidate yet, spurious ID
    check("R2 empty hp_id", 32'(hp_id), 32'd1023);

    // R2 R6 R7: table of cumulative configurations
    for (int k = 0; k < 6; k++) begin
      configure(VECS[k].id, VECS[k].en, VECS[k].grp, VECS[k].prio);
      make_pending(VECS[k].id);
      settle();
      expect_out($sformatf("R2/R7 vec%0d", k), VECS[k].exp_id, VECS[k].exp_irq,
                 VECS[k].exp_fiq, 8'hFF);
    end

    // R3 R4: mask equal to the priority blocks signalling, hp_id unchanged
    pmr = 8'h40;
    settle();
    expect_out("R3/R4 masked", 10'd7, 1'b0, 1'b0, 8'hFF);
    check("R3 hp_prio", 32'(hp_prio), 32'h40);
    pmr = 8'hF0;

    // R6: group 1 current disabled
    grp_en = 3'b101;
    settle();
    expect_out("R6 grp off", 10'd7, 1'b0, 1'b0, 8'hFF);
    grp_en = 3'b111;
    settle();

    // R8 R5: ack 7, then 9 (same priority) cannot preempt
    pulse_ack();
    settle();
    expect_out("R8/R5 after ack", 10'd9, 1'b0, 1'b0, 8'h40);

    // R8: ack while nothing signalled is ignored
    pulse_ack();
    settle();
    expect_out("R8 idle ack", 10'd9, 1'b0, 1'b0, 8'h40);

    // R5: a higher-priority interrupt preempts
    configure(4'd12, 1'b1, 2'd1, 8'h10);
    settle();
    expect_out("R5 preempt", 10'd12, 1'b1, 1'b0, 8'h40);
    pulse_ack();
    settle();
    expect_out("R8 nested ack", 10'd9, 1'b0, 1'b0, 8'h10);

    // R10: re-pending an active interrupt does not make it a candidate
    make_pending(4'd7);
    settle();
    expect_out("R10 active pend", 10'd9, 1'b0, 1'b0, 8'h10);

    // R9: EOI of an ID that is not active is ignored
    pulse_eoi(4'd4);
    settle();
    expect_out("R9 stray eoi", 10'd9, 1'b0, 1'b0, 8'h10);
    pulse_eoi(4'd12);
    settle();
    expect_out("R9 eoi 12", 10'd9, 1'b0, 1'b0, 8'h40);
    pulse_eoi(4'd7);
    settle();
    expect_out("R9/R10 eoi 7", 10'd7, 1'b1, 1'b0, 8'hFF);

    // R11: depth two, a third acknowledge is ignored
    pulse_ack();
    configure(4'd2, 1'b1, 2'd0, 8'h08);
    make_pending(4'd2);
    settle();
    expect_out("R11 step1", 10'd2, 1'b0, 1'b1, 8'h40);
    pulse_ack();
    configure(4'd1, 1'b1, 2'd1, 8'h04);
    make_pending(4'd1);
    settle();
    expect_out("R11 step2", 10'd1, 1'b1, 1'b0, 8'h08);
    pulse_ack();
    settle();
    expect_out("R11 full ack", 10'd1, 1'b1, 1'b0, 8'h08);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule